// File: doc/BRIEF.md
# Interrupt Controller Programming Sequencer

This block is the configuration front end of an eight-input interrupt controller. A host writes bytes through a small port made of a data byte, a single address bit and a write strobe. After reset the block is uninitialized. It accepts a fixed series of setup bytes and walks through them in order. The length of that series is decided at run time by flags carried in the first byte. Once the series is complete, later writes are taken as run-time commands.

The block holds the controller's configuration and exports it as registered outputs. This covers the input trigger style, the vector base, single or chained operation, the chaining byte, automatic end-of-interrupt, nested handling of chained requests and the eight-bit input mask. It forms the interrupt vector from the stored base and a supplied input number. The two run-time command kinds that belong to other blocks are each passed on as a one-cycle strobe with the command byte. Priority logic, in-service tracking and the acknowledge cycle lie outside this block.

Top module: `irq_cfg_sequencer`

## Requirements
- R1: After a synchronous reset, init_done, irq_mask, level_trig, single_mode, vec_base, cascade_cfg, auto_eoi, fully_nested, rd_data and both command strobes are all 0.
- R2: A write with addr=0 and wr_data[4]=1 starts setup again from any state. On the next cycle init_done is 0, and irq_mask, auto_eoi, fully_nested and cascade_cfg are all 0.
- R3: The start byte (addr=0, bit 4=1) loads level_trig from bit 3 (1 = level, 0 = edge) and single_mode from bit 1 (1 = single, 0 = chained). Bit 0 = 1 requests the options byte.
- R4: The next addr=1 write after the start byte loads vec_base from wr_data[7:3]. The vector output equals {vec_base, irq_num}, one cycle after irq_num is applied.
- R5: In chained mode, the addr=1 write after the base byte is stored in cascade_cfg. In single mode no chaining byte is expected, and cascade_cfg stays 0.
- R6: When requested, the options byte is the last setup write. It loads auto_eoi from bit 1 and fully_nested from bit 4, and init_done rises on the following cycle. When the options byte is not requested, init_done rises right after the base byte (or after the chaining byte), and auto_eoi and fully_nested stay 0.
- R7: Once init_done is 1, every addr=1 write loads irq_mask with wr_data. A 1 in a bit masks that input.
- R8: Once init_done is 1, an addr=0 write with wr_data[4:3]=00 pulses eoi_stb for one cycle with eoi_data equal to the byte. With wr_data[4:3]=01 it pulses poll_stb and poll_data in the same way. While init_done is 0, neither strobe fires.
- R9: A cycle with rd_en=1 sets rd_data on the next cycle: to irq_mask when addr=1, or to 0 when addr=0.
- R10: Before the first start byte after reset, addr=1 writes are ignored: irq_mask stays 0 and init_done stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | Address bit for reads and writes |
| wr_data | input | 8 | Write data byte |
| irq_num | input | 3 | Input number used to form the vector |
| init_done | output | 1 | Setup series complete |
| level_trig | output | 1 | 1 = level-triggered inputs, 0 = edge |
| single_mode | output | 1 | 1 = single controller, 0 = chained |
| vec_base | output | 5 | Vector base (upper vector bits) |
| cascade_cfg | output | 8 | Stored chaining byte |
| auto_eoi | output | 1 | Automatic end-of-interrupt enabled |
| fully_nested | output | 1 | Nested handling of chained requests |
| irq_mask | output | 8 | Input mask, 1 = masked |
| vector | output | 8 | {vec_base, irq_num}, registered |
| rd_data | output | 8 | Read result |
| eoi_stb | output | 1 | End-of-interrupt/priority command strobe |
| eoi_data | output | 8 | Byte of the last such command |
| poll_stb | output | 1 | Poll/read-select command strobe |
| poll_data | output | 8 | Byte of the last such command |

## Verification
The sequencer's state is hidden, so a wrong state can only be seen through side effects. An expected setup byte that lands in the wrong place will show as a wrong vec_base, cascade_cfg or auto_eoi one cycle after the write. A skipped or extra step will show as init_done rising one write early or late. A state stuck outside the ready state will show on the next write: a mask load has no effect, or a command produces no strobe. A restart that fails to clear state will leave irq_mask or auto_eoi nonzero on the cycle after the start byte.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;
  typedef enum logic [2:0] {
    ST_UNINIT,
    ST_BASE,
    ST_CHAIN,
    ST_OPTS,
    ST_READY
  } seq_state_t;

  // bit positions inside the written byte
  localparam int START_BIT  = 4;
  localparam int OPSEL_BIT  = 3;
  localparam int LEVEL_BIT  = 3;
  localparam int SINGLE_BIT = 1;
  localparam int NEEDOPT_BIT = 0;
  localparam int AEOI_BIT   = 1;
  localparam int NEST_BIT   = 4;
endpackage

// File: rtl/irqseq_fsm.sv
module irqseq_fsm
  import irqseq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic addr,
  input  logic d_start,
  input  logic d_opsel,
  input  logic d_single,
  input  logic d_needopt,
  output logic ld_start,
  output logic ld_base,
  output logic ld_chain,
  output logic ld_opts,
  output logic ld_mask,
  output logic op_eoi,
  output logic op_poll,
  output logic init_done
);
  seq_state_t state;
  logic need_chain;
  logic need_opts;

  always_comb begin
    ld_start = wr_en && !addr && d_start;
    ld_base  = wr_en && addr && (state == ST_BASE);
    ld_chain = wr_en && addr && (state == ST_CHAIN);
    ld_opts  = wr_en && addr && (state == ST_OPTS);
    ld_mask  = wr_en && addr && (state == ST_READY);
    op_eoi   = wr_en && !addr && !d_start && !d_opsel && (state == ST_READY);
    op_poll  = wr_en && !addr && !d_start && d_opsel && (state == ST_READY);
    init_done = (state == ST_READY);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_UNINIT;
      need_chain <= 1'b0;
      need_opts  <= 1'b0;
    end else if (ld_start) begin
      state      <= ST_BASE;
      need_chain <= !d_single;
      need_opts  <= d_needopt;
    end else if (ld_base) begin
      if (need_chain)     state <= ST_CHAIN;
      else if (need_opts) state <= ST_OPTS;
      else                state <= ST_READY;
    end else if (ld_chain) begin
      state <= need_opts ? ST_OPTS : ST_READY;
    end else if (ld_opts) begin
      state <= ST_READY;
    end
  end

  // R2: start byte always returns the sequencer to the base step
  p_restart_r2: assert property (@(posedge clk) disable iff (rst)
    ld_start |=> (state == ST_BASE) && !init_done);
  // R5: chained mode inserts the chaining step after the base byte
  p_chain_step_r5: assert property (@(posedge clk) disable iff (rst)
    (ld_base && need_chain) |=> (state == ST_CHAIN));
  // R6: without options request, setup ends right after the base byte in single mode
  p_skip_opts_r6: assert property (@(posedge clk) disable iff (rst)
    (ld_base && !need_chain && !need_opts) |=> init_done);
  // R10: addr=1 writes before any start byte change nothing
  p_uninit_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_UNINIT && !ld_start) |=> (state == ST_UNINIT));
endmodule

// File: rtl/irqseq_cfg.sv
module irqseq_cfg
  import irqseq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3,
  localparam int BASE_W = DATA_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_start,
  input  logic              ld_base,
  input  logic              ld_chain,
  input  logic              ld_opts,
  input  logic              ld_mask,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  irq_num,
  output logic              level_trig,
  output logic              single_mode,
  output logic [BASE_W-1:0] vec_base,
  output logic [DATA_W-1:0] cascade_cfg,
  output logic              auto_eoi,
  output logic              fully_nested,
  output logic [DATA_W-1:0] irq_mask,
  output logic [DATA_W-1:0] vector,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      level_trig   <= 1'b0;
      single_mode  <= 1'b0;
      vec_base     <= '0;
      cascade_cfg  <= '0;
      auto_eoi     <= 1'b0;
      fully_nested <= 1'b0;
      irq_mask     <= '0;
    end else begin
      if (ld_start) begin
        level_trig   <= wr_data[LEVEL_BIT];
        single_mode  <= wr_data[SINGLE_BIT];
        cascade_cfg  <= '0;
        auto_eoi     <= 1'b0;
        fully_nested <= 1'b0;
        irq_mask     <= '0;
      end
      if (ld_base)  vec_base    <= wr_data[DATA_W-1:IDX_W];
      if (ld_chain) cascade_cfg <= wr_data;
      if (ld_opts) begin
        auto_eoi     <= wr_data[AEOI_BIT];
        fully_nested <= wr_data[NEST_BIT];
      end
      if (ld_mask)  irq_mask    <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vector  <= '0;
      rd_data <= '0;
    end else begin
      vector <= {vec_base, irq_num};
      if (rd_en) rd_data <= addr ? irq_mask : '0;
    end
  end

  // R2: restart clears mask and automatic end-of-interrupt
  p_start_clears_r2: assert property (@(posedge clk) disable iff (rst)
    ld_start |=> (irq_mask == '0) && !auto_eoi && !fully_nested);
  // R7: mask load takes the written byte
  p_mask_load_r7: assert property (@(posedge clk) disable iff (rst)
    ld_mask |=> (irq_mask == $past(wr_data)));
  // R9: read with addr=0 returns zero
  p_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !addr) |=> (rd_data == '0));
endmodule

// File: rtl/irqseq_opdec.sv
module irqseq_opdec #(
  parameter int DATA_W  = 8,
  parameter int NUM_OPS = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_OPS-1:0]             hit,
  input  logic                           init_done,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [NUM_OPS-1:0]             stb,
  output logic [NUM_OPS-1:0][DATA_W-1:0] cmd
);
  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    always_ff @(posedge clk) begin
      if (rst) begin
        stb[g] <= 1'b0;
        cmd[g] <= '0;
      end else begin
        stb[g] <= hit[g];
        if (hit[g]) cmd[g] <= wr_data;
      end
    end
  end

  // R8: at most one command strobe per cycle
  p_one_cmd_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stb));
  // R8: a strobe only follows a write made while initialized
  p_cmd_needs_init_r8: assert property (@(posedge clk) disable iff (rst)
    (|stb) |-> $past(init_done));
endmodule

// File: rtl/irq_cfg_sequencer.sv
module irq_cfg_sequencer
  import irqseq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_IN = 8,
  localparam int IDX_W  = $clog2(NUM_IN),
  localparam int BASE_W = DATA_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  irq_num,
  output logic              init_done,
  output logic              level_trig,
  output logic              single_mode,
  output logic [BASE_W-1:0] vec_base,
  output logic [DATA_W-1:0] cascade_cfg,
  output logic              auto_eoi,
  output logic              fully_nested,
  output logic [DATA_W-1:0] irq_mask,
  output logic [DATA_W-1:0] vector,
  output logic [DATA_W-1:0] rd_data,
  output logic              eoi_stb,
  output logic [DATA_W-1:0] eoi_data,
  output logic              poll_stb,
  output logic [DATA_W-1:0] poll_data
);
  localparam int NUM_OPS = 2;

  logic ld_start, ld_base, ld_chain, ld_opts, ld_mask, op_eoi, op_poll;
  logic [NUM_OPS-1:0]             op_stb;
  logic [NUM_OPS-1:0][DATA_W-1:0] op_cmd;

  irqseq_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .d_start   (wr_data[START_BIT]),
    .d_opsel   (wr_data[OPSEL_BIT]),
    .d_single  (wr_data[SINGLE_BIT]),
    .d_needopt (wr_data[NEEDOPT_BIT]),
    .ld_start  (ld_start),
    .ld_base   (ld_base),
    .ld_chain  (ld_chain),
    .ld_opts   (ld_opts),
    .ld_mask   (ld_mask),
    .op_eoi    (op_eoi),
    .op_poll   (op_poll),
    .init_done (init_done)
  );

  irqseq_cfg #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_cfg (
    .clk          (clk),
    .rst          (rst),
    .ld_start     (ld_start),
    .ld_base      (ld_base),
    .ld_chain     (ld_chain),
    .ld_opts      (ld_opts),
    .ld_mask      (ld_mask),
    .rd_en        (rd_en),
    .addr         (addr),
    .wr_data      (wr_data),
    .irq_num      (irq_num),
    .level_trig   (level_trig),
    .single_mode  (single_mode),
    .vec_base     (vec_base),
    .cascade_cfg  (cascade_cfg),
    .auto_eoi     (auto_eoi),
    .fully_nested (fully_nested),
    .irq_mask     (irq_mask),
    .vector       (vector),
    .rd_data      (rd_data)
  );

  irqseq_opdec #(.DATA_W(DATA_W), .NUM_OPS(NUM_OPS)) u_opdec (
    .clk       (clk),
    .rst       (rst),
    .hit       ({op_poll, op_eoi}),
    .init_done (init_done),
    .wr_data   (wr_data),
    .stb       (op_stb),
    .cmd       (op_cmd)
  );

  assign eoi_stb   = op_stb[0];
  assign eoi_data  = op_cmd[0];
  assign poll_stb  = op_stb[1];
  assign poll_data = op_cmd[1];
endmodule

// File: tb/irq_cfg_sequencer_tb_top.sv
`timescale 1ns/1ps
module irq_cfg_sequencer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [2:0] irq_num = 3'd0;
  logic       init_done, level_trig, single_mode, auto_eoi, fully_nested;
  logic [4:0] vec_base;
  logic [7:0] cascade_cfg, irq_mask, vector, rd_data, eoi_data, poll_data;
  logic       eoi_stb, poll_stb;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  irq_cfg_sequencer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .irq_num(irq_num), .init_done(init_done),
    .level_trig(level_trig), .single_mode(single_mode), .vec_base(vec_base),
    .cascade_cfg(cascade_cfg), .auto_eoi(auto_eoi), .fully_nested(fully_nested),
    .irq_mask(irq_mask), .vector(vector), .rd_data(rd_data),
    .eoi_stb(eoi_stb), .eoi_data(eoi_data), .poll_stb(poll_stb),
    .poll_data(poll_data)
  );

  // entry: [23]eoi [22]poll [21:18]req [17]addr [16:9]data [8]init [7:0]mask
  localparam int NV = 11;
  localparam logic [23:0] VECS [NV] = '{
    {1'b0, 1'b0, 4'd10, 1'b1, 8'hFF, 1'b0, 8'h00},
    {1'b0, 1'b0, 4'd3,  1'b0, 8'h1B, 1'b0, 8'h00},
    {1'b0, 1'b0, 4'd4,  1'b1, 8'h40, 1'b0, 8'h00},
    {1'b0, 1'b0, 4'd6,  1'b1, 8'h03, 1'b1, 8'h00},
    {1'b0, 1'b0, 4'd7,  1'b1, 8'hA5, 1'b1, 8'hA5},
    {1'b1, 1'b0, 4'd8,  1'b0, 8'h20, 1'b1, 8'hA5},
    {1'b0, 1'b1, 4'd8,  1'b0, 8'h0C, 1'b1, 8'hA5},
    {1'b0, 1'b0, 4'd2,  1'b0, 8'h10, 1'b0, 8'h00},
    {1'b0, 1'b0, 4'd4,  1'b1, 8'h08, 1'b0, 8'h00},
    {1'b0, 1'b0, 4'd5,  1'b1, 8'hF0, 1'b1, 8'h00},
    {1'b0, 1'b0, 4'd7,  1'b1, 8'h3C, 1'b1, 8'h3C}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive at a falling edge, release at the next; results sampled then
  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 1'b0; wr_data = 8'h00;
  endtask

  task automatic rd(input logic a);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0; addr = 1'b0;
  endtask

  task automatic do_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1: reset state
    chk("R1", "init_done", init_done, 0);
    chk("R1", "irq_mask", irq_mask, 0);
    chk("R1", "cfg", {level_trig, single_mode, auto_eoi, fully_nested}, 0);
    chk("R1", "vec_base/cascade", {vec_base, cascade_cfg}, 0);
    chk("R1", "strobes/rd", {eoi_stb, poll_stb, rd_data}, 0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i][21:18]);
      wr(VECS[i][17], VECS[i][16:9]);
      chk(tag, $sformatf("vec%0d init_done", i), init_done, VECS[i][8]);
      chk(tag, $sformatf("vec%0d irq_mask", i), irq_mask, VECS[i][7:0]);
      chk(tag, $sformatf("vec%0d strobes", i), {eoi_stb, poll_stb}, VECS[i][23:22]);
    end

    // directed: full single-mode setup with options
    do_reset();
    wr(1'b0, 8'h1B);
    chk("R3", "level_trig", level_trig, 1);
    chk("R3", "single_mode", single_mode, 1);
    wr(1'b1, 8'h40);
    chk("R4", "vec_base", vec_base, 5'h08);
    irq_num = 3'd5;
    @(negedge clk);
    chk("R4", "vector", vector, 8'h45);
    wr(1'b1, 8'h12);
    chk("R6", "auto_eoi/nested", {auto_eoi, fully_nested}, 2'b11);
    chk("R6", "init_done", init_done, 1);
    chk("R5", "cascade_cfg single", cascade_cfg, 0);
    wr(1'b1, 8'h81);
    rd(1'b1);
    chk("R9", "rd mask", rd_data, 8'h81);
    rd(1'b0);
    chk("R9", "rd addr0", rd_data, 8'h00);
    wr(1'b0, 8'h27);
    chk("R8", "eoi_data", eoi_data, 8'h27);
    @(negedge clk);
    chk("R8", "eoi one cycle", eoi_stb, 0);

    // chained restart with options requested
    wr(1'b0, 8'h11);
    chk("R2", "mask cleared", irq_mask, 0);
    chk("R2", "aeoi/nested cleared", {auto_eoi, fully_nested}, 0);
    chk("R2", "init_done low", init_done, 0);
    chk("R3", "edge/chained", {level_trig, single_mode}, 0);
    wr(1'b1, 8'h88);
    wr(1'b1, 8'h04);
    chk("R5", "cascade_cfg", cascade_cfg, 8'h04);
    chk("R5", "still waiting", init_done, 0);
    wr(1'b0, 8'h20);
    chk("R8", "no strobe during setup", {eoi_stb, poll_stb}, 0);
    wr(1'b1, 8'h00);
    chk("R6", "init after options", init_done, 1);
    chk("R6", "aeoi zero", auto_eoi, 0);
    wr(1'b1, 8'h5A);
    chk("R7", "mask load", irq_mask, 8'h5A);

    // single, no options: done right after base byte
    wr(1'b0, 8'h12);
    wr(1'b1, 8'hF8);
    chk("R6", "init after base", init_done, 1);
    chk("R4", "base F8", vec_base, 5'h1F);
    chk("R5", "no chaining byte", cascade_cfg, 0);
    wr(1'b1, 8'h77);
    chk("R7", "mask after short setup", irq_mask, 8'h77);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule